// File: doc/BRIEF.md
# Single-Position Shift Unit

This combinational block moves an n-bit register value by exactly one bit position. A 3-bit operation code picks one of six shifts: logical, circular or arithmetic, each to the left or to the right. Any other code passes the operand through unchanged. The logical shifts take their incoming bit from a serial input pin. The circular shifts recycle the bit that falls off one end. The arithmetic shifts either insert a zero at the bottom or replicate the sign at the top.

Next to the shifted value, the block reports two things. The first is the bit that leaves the register. The second is an overflow flag, which is raised when an arithmetic left shift would change the sign. The unit is meant to sit in a datapath behind an operand multiplexer, with its outputs captured by whatever register is the destination of the operation.

Top module: `shift_uop_unit`

## Requirements
- R1: Code 000 (logical left) gives result = {operand[W-2:0], serial} and spill = operand[W-1].
- R2: Code 001 (logical right) gives result = {serial, operand[W-1:1]} and spill = operand[0].
- R3: Code 010 (circular left) gives result = {operand[W-2:0], operand[W-1]}, so the population count is preserved.
- R4: Code 011 (circular right) gives result = {operand[0], operand[W-1:1]}.
- R5: Code 100 (arithmetic left) gives result = {operand[W-2:0], 1'b0} and spill = operand[W-1].
- R6: Code 101 (arithmetic right) gives result = {operand[W-1], operand[W-1:1]}, which keeps the sign bit, and spill = operand[0].
- R7: Under code 100, overflow equals operand[W-1] XOR operand[W-2]: it is 1 for top bits 01 and 10, and 0 for top bits 00 and 11.
- R8: Overflow is 0 under every code other than 100.
- R9: Spill is 0 under codes 010, 011, 110 and 111.
- R10: Codes 110 and 111 return the operand unchanged. The serial input has no effect on any code except 000 and 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | WIDTH | Value to be shifted |
| op_i | input | 3 | Shift selection code |
| serial_i | input | 1 | Bit inserted by the logical shifts |
| result_o | output | WIDTH | Shifted value |
| spill_o | output | 1 | Bit that left the register |
| ovf_o | output | 1 | Sign change under arithmetic left shift |

## Verification
An arithmetic left shift produces its result, its spill bit and its overflow flag together, from the same two top operand bits. The sweep covers every operand under code 100, which includes all four top-bit patterns 00, 01, 10 and 11. In each case all three outputs are judged against values the bench works out arithmetically. The same full sweep runs for the arithmetic right shift, so negative operands show whether sign replication and the spill of the LSB happen at once. It is repeated with the serial bit at both levels, so any leak of the serial input into a non-logical code shows up as a wrong result.

// File: rtl/shift_uop_pkg.sv
package shift_uop_pkg;

   typedef enum logic [2:0] {
      OP_SLL  = 3'b000,
      OP_SRL  = 3'b001,
      OP_ROL  = 3'b010,
      OP_ROR  = 3'b011,
      OP_ASL  = 3'b100,
      OP_ASR  = 3'b101,
      OP_PAS6 = 3'b110,
      OP_PAS7 = 3'b111
   } shop_e;

   typedef enum logic [1:0] {
      FILL_SER  = 2'd0,
      FILL_WRAP = 2'd1,
      FILL_ZERO = 2'd2,
      FILL_SIGN = 2'd3
   } fill_e;

   typedef struct packed {
      logic  go_left;
      logic  go_right;
      logic  drops;
      logic  asl;
      fill_e fill;
   } shctl_t;

endpackage

// File: rtl/shift_uop_ctrl.sv
module shift_uop_ctrl
   import shift_uop_pkg::*;
(
   input  logic [2:0] op_i,
   output shctl_t     ctl_o
);

   always_comb begin
      ctl_o = '{go_left: 1'b0, go_right: 1'b0, drops: 1'b0, asl: 1'b0, fill: FILL_ZERO};
      case (shop_e'(op_i))
         OP_SLL: begin
            ctl_o.go_left = 1'b1;
            ctl_o.drops   = 1'b1;
            ctl_o.fill    = FILL_SER;
         end
         OP_SRL: begin
            ctl_o.go_right = 1'b1;
            ctl_o.drops    = 1'b1;
            ctl_o.fill     = FILL_SER;
         end
         OP_ROL: begin
            ctl_o.go_left = 1'b1;
            ctl_o.fill    = FILL_WRAP;
         end
         OP_ROR: begin
            ctl_o.go_right = 1'b1;
            ctl_o.fill     = FILL_WRAP;
         end
         OP_ASL: begin
            ctl_o.go_left = 1'b1;
            ctl_o.drops   = 1'b1;
            ctl_o.asl     = 1'b1;
            ctl_o.fill    = FILL_ZERO;
         end
         OP_ASR: begin
            ctl_o.go_right = 1'b1;
            ctl_o.drops    = 1'b1;
            ctl_o.fill     = FILL_SIGN;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/shift_uop_fill.sv
module shift_uop_fill
   import shift_uop_pkg::*;
(
   input  fill_e fill_i,
   input  logic  go_left_i,
   input  logic  serial_i,
   input  logic  msb_i,
   input  logic  lsb_i,
   output logic  fill_o
);

   always_comb begin
      case (fill_i)
         FILL_SER:  fill_o = serial_i;
         FILL_WRAP: fill_o = go_left_i ? msb_i : lsb_i;
         FILL_SIGN: fill_o = msb_i;
         default:   fill_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/shift_uop_lane.sv
module shift_uop_lane #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             go_left_i,
   input  logic             go_right_i,
   input  logic             fill_i,
   output logic [WIDTH-1:0] y_o
);

   localparam int TOP = WIDTH - 1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_low;
      logic from_high;

      if (i == 0) begin : g_bottom
         assign from_low = fill_i;
      end else begin : g_mid_lo
         assign from_low = a_i[i-1];
      end

      if (i == TOP) begin : g_top
         assign from_high = fill_i;
      end else begin : g_mid_hi
         assign from_high = a_i[i+1];
      end

      always_comb begin
         if (go_left_i)       y_o[i] = from_low;
         else if (go_right_i) y_o[i] = from_high;
         else                 y_o[i] = a_i[i];
      end
   end

endmodule

// File: rtl/shift_uop_flags.sv
module shift_uop_flags (
   input  logic msb_i,
   input  logic next_i,
   input  logic lsb_i,
   input  logic go_left_i,
   input  logic go_right_i,
   input  logic drops_i,
   input  logic asl_i,
   output logic spill_o,
   output logic ovf_o
);

   always_comb begin
      spill_o = 1'b0;
      if (drops_i && go_left_i)  spill_o = msb_i;
      if (drops_i && go_right_i) spill_o = lsb_i;
      ovf_o = asl_i & (msb_i ^ next_i);
   end

   always_comb begin
      if (!asl_i) begin
         p_no_overflow_r8: assert (!ovf_o);
      end
      if (!drops_i) begin
         p_nothing_spills_r9: assert (!spill_o);
      end
   end

endmodule

// File: rtl/shift_uop_unit.sv
module shift_uop_unit
   import shift_uop_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] operand_i,
   input  logic [2:0]       op_i,
   input  logic             serial_i,
   output logic [WIDTH-1:0] result_o,
   output logic             spill_o,
   output logic             ovf_o
);

   localparam int MSB = WIDTH - 1;
   localparam int NXT = WIDTH - 2;

   if (WIDTH < 2) begin : g_bad_width
      $error("shift_uop_unit: WIDTH must be at least 2");
   end

   shctl_t ctl;
   logic   fill_bit;

   shift_uop_ctrl u_ctrl (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   shift_uop_fill u_fill (
      .fill_i    (ctl.fill),
      .go_left_i (ctl.go_left),
      .serial_i  (serial_i),
      .msb_i     (operand_i[MSB]),
      .lsb_i     (operand_i[0]),
      .fill_o    (fill_bit)
   );

   shift_uop_lane #(.WIDTH(WIDTH)) u_lane (
      .a_i        (operand_i),
      .go_left_i  (ctl.go_left),
      .go_right_i (ctl.go_right),
      .fill_i     (fill_bit),
      .y_o        (result_o)
   );

   shift_uop_flags u_flags (
      .msb_i      (operand_i[MSB]),
      .next_i     (operand_i[NXT]),
      .lsb_i      (operand_i[0]),
      .go_left_i  (ctl.go_left),
      .go_right_i (ctl.go_right),
      .drops_i    (ctl.drops),
      .asl_i      (ctl.asl),
      .spill_o    (spill_o),
      .ovf_o      (ovf_o)
   );

   always_comb begin
      if (op_i == 3'(OP_SLL)) begin
         p_serial_enters_r1: assert (result_o[0] == serial_i);
      end
      if (op_i == 3'(OP_ROL) || op_i == 3'(OP_ROR)) begin
         p_ones_kept_r3: assert ($countones(result_o) == $countones(operand_i));
      end
      if (op_i == 3'(OP_ASL)) begin
         p_zero_enters_r5: assert (!result_o[0]);
      end
      if (op_i == 3'(OP_ASR)) begin
         p_sign_kept_r6: assert (result_o[MSB] == operand_i[MSB]);
      end
      if (op_i[2:1] == 2'b11) begin
         p_pass_through_r10: assert (result_o == operand_i);
      end
   end

endmodule

// File: tb/shift_uop_unit_tb.sv
module shift_uop_unit_tb;

   localparam int W = 8;
   localparam int M = 1 << W;
   localparam int H = M / 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] operand;
   logic [2:0]   op;
   logic         serial;
   logic [W-1:0] result;
   logic         spill;
   logic         ovf;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   shift_uop_unit #(.WIDTH(W)) u_dut (
      .operand_i (operand),
      .op_i      (op),
      .serial_i  (serial),
      .result_o  (result),
      .spill_o   (spill),
      .ovf_o     (ovf)
   );

   function automatic string res_tag(int c);
      case (c)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s op=%0d a=%0h sin=%0d actual=%0h expected=%0h",
                  tag, what, op, operand, serial, act, exp);
      end
   endtask

   task automatic apply(int a, int c, int s);
      @(negedge clk);
      operand = W'(a);
      op      = 3'(c);
      serial  = s[0];
      #1;
   endtask

   task automatic sweep_one(int a, int c, int s);
      int ey;
      int esp;
      int eov;
      ey  = a;
      esp = 0;
      eov = 0;
      case (c)
         0: begin ey = (a * 2) % M + s;       esp = a / H; end
         1: begin ey = a / 2 + s * H;         esp = a % 2; end
         2: begin ey = (a * 2) % M + a / H;   end
         3: begin ey = a / 2 + (a % 2) * H;   end
         4: begin ey = (a * 2) % M;           esp = a / H;
                  eov = ((a / H) != ((a / (H / 2)) % 2)) ? 1 : 0; end
         5: begin ey = a / 2 + (a / H) * H;   esp = a % 2; end
         default: ;
      endcase
      apply(a, c, s);
      check(res_tag(c), "result", int'(result), ey);
      check((c == 2 || c == 3 || c > 5) ? "R9" : res_tag(c), "spill", int'(spill), esp);
      check((c == 4) ? "R7" : "R8", "overflow", int'(ovf), eov);
   endtask

   initial begin
      operand = '0;
      op      = 3'b000;
      serial  = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1", "idle result", int'(result), 0);
      check("R8", "idle overflow", int'(ovf), 0);

      for (int c = 0; c < 8; c++) begin
         for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < M; a++) begin
               sweep_one(a, c, s);
            end
         end
      end

      // R6: negative operands keep their sign under the arithmetic right shift
      apply(8'h80, 5, 1);
      check("R6", "asr 80", int'(result), 8'hC0);
      apply(8'hFF, 5, 0);
      check("R6", "asr FF", int'(result), 8'hFF);
      check("R6", "asr FF spill", int'(spill), 1);
      apply(8'hB5, 5, 1);
      check("R6", "asr B5", int'(result), 8'hDA);

      // R7: overflow on top bits 01 and 10, none on 00 and 11
      apply(8'h5A, 4, 1);
      check("R7", "asl 01xx ovf", int'(ovf), 1);
      check("R5", "asl 5A", int'(result), 8'hB4);
      apply(8'hA3, 4, 0);
      check("R7", "asl 10xx ovf", int'(ovf), 1);
      apply(8'hC3, 4, 0);
      check("R7", "asl 11xx ovf", int'(ovf), 0);
      apply(8'h3F, 4, 1);
      check("R7", "asl 00xx ovf", int'(ovf), 0);

      // R10: serial level has no effect on the circular shifts
      apply(8'h81, 2, 1);
      check("R10", "rol 81 sin1", int'(result), 8'h03);
      apply(8'h81, 3, 0);
      check("R10", "ror 81 sin0", int'(result), 8'hC0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule